// File: doc/BRIEF.md
# Hybrid Karatsuba Carry-Less Polynomial Multiplier

This block takes two N-bit binary polynomials, with coefficients in GF(2), and returns their full, unreduced product of 2N-1 bits. Bit k of each operand is the coefficient of x^k. It does no modular reduction. A separate reduction stage is expected to consume the product. Addition and subtraction of coefficients are both XOR, so no carries exist anywhere in the datapath.

The multiplier is a combinational tree. At upper levels it splits each operand into a low half and a high half, and forms three half-size products: low by low, high by high, and the XOR-sum of the halves multiplied together. When the width is odd, the high half is one bit wider. Once a sub-operand is no wider than a threshold width, the tree switches to a three-group leaf. That leaf cuts each operand into three zero-padded groups of width g and forms six group products. The leaf then merges their XOR combinations at offsets 0, g, 2g, 3g and 4g.

An optional output register gives one cycle of latency and an asynchronous active-low reset. It is built as a parameterized tree, so the split depth follows from N and the threshold.

Top module: `hk_polymul`

There are no states. The tree is pure logic. The only storage is the optional product register, which has two conditions. It is cleared while reset is asserted. Otherwise it loads the tree result on every rising clock edge.

## Requirements
- R1: `prod` equals the carry-less product of `a` and `b`. Bit k of the product is the XOR over all i+j=k of a[i]&b[j], for every operand pair and any legal N and THRESH.
- R2: If either operand is zero, the product is zero.
- R3: If one operand equals 1 (only bit 0 set), the product equals the other operand in bits N-1..0, with all higher bits zero.
- R4: If a has only bit i set and b has only bit j set, the product has exactly one bit set, at index i+j.
- R5: Product bit 2N-2 equals a[N-1]&b[N-1], and product bit 0 equals a[0]&b[0]. For all-ones operands, the full product matches R1.
- R6: With OUT_REG=1, `prod` shows the product of the operands sampled at the most recent rising clock edge, and it holds between edges. With OUT_REG=0, `prod` follows the operands with no clock.
- R7: With OUT_REG=1, `prod` reads zero while `rst_n` is low, whatever the operands are.
- R8: The product is symmetric: swapping `a` and `b` gives the same `prod`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional product register |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| a | input | N | First operand polynomial, bit k is the x^k coefficient |
| b | input | N | Second operand polynomial |
| prod | output | 2N-1 | Unreduced product polynomial |

## Verification
The bench builds the block three times:
- **N=8, THRESH=3, no register.** Every one of the 65,536 operand pairs is swept, through a tree that splits twice down to 2-bit leaves.
- **N=13, THRESH=5, registered.** This brings in odd splits (6/7), a padded leaf (a 4-bit leaf with 2-bit groups) and the register's latency and reset. All 169 single-bit pairs are checked, plus random pairs.
- **Default build (N=233).** This is driven with corner and random operands, so the deep odd-width recursion at full size is covered.

// File: rtl/hk_pkg.sv
`timescale 1ns/1ps
package hk_pkg;

    // Width of the low half at a split level (high half takes the extra bit).
    function automatic int low_half(input int w);
        return w / 2;
    endfunction

    // Group width of the three-group leaf for a w-bit operand.
    function automatic int leaf_group(input int w);
        return (w + 2) / 3;
    endfunction

    // Width of an unreduced product of two w-bit polynomials.
    function automatic int prod_width(input int w);
        return 2 * w - 1;
    endfunction

    // Whether a w-bit sub-product is built as a leaf.
    function automatic bit is_leaf(input int w, input int thresh);
        return (w <= thresh) || (w < 4);
    endfunction

endpackage

// File: rtl/hk_school.sv
`timescale 1ns/1ps
module hk_school #(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-2:0]   p
);
    // Direct AND/XOR product for the small groups inside a leaf.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                p[i+j] = p[i+j] ^ (a[i] & b[j]);
            end
        end
    end
endmodule

// File: rtl/hk_leaf3.sv
`timescale 1ns/1ps
module hk_leaf3
    import hk_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-2:0]   p
);
    localparam int G  = leaf_group(W);
    localparam int PG = 3 * G;
    localparam int DW = prod_width(G);
    localparam int FW = prod_width(PG);
    localparam int PW = prod_width(W);

    logic [PG-1:0] ap, bp;
    logic [G-1:0]  a0, a1, a2, b0, b1, b2;
    logic [G-1:0]  s01a, s01b, s02a, s02b, s12a, s12b;
    logic [DW-1:0] d0, d1, d2, d01, d02, d12;
    logic [DW-1:0] t1, t2, t3;

    // zero-pad operands up to three full groups
    assign ap = PG'(a);
    assign bp = PG'(b);

    assign a0 = ap[G-1:0];
    assign a1 = ap[2*G-1:G];
    assign a2 = ap[3*G-1:2*G];
    assign b0 = bp[G-1:0];
    assign b1 = bp[2*G-1:G];
    assign b2 = bp[3*G-1:2*G];

    assign s01a = a0 ^ a1;
    assign s01b = b0 ^ b1;
    assign s02a = a0 ^ a2;
    assign s02b = b0 ^ b2;
    assign s12a = a1 ^ a2;
    assign s12b = b1 ^ b2;

    hk_school #(.W(G)) u_d0  (.a(a0),   .b(b0),   .p(d0));
    hk_school #(.W(G)) u_d1  (.a(a1),   .b(b1),   .p(d1));
    hk_school #(.W(G)) u_d2  (.a(a2),   .b(b2),   .p(d2));
    hk_school #(.W(G)) u_d01 (.a(s01a), .b(s01b), .p(d01));
    hk_school #(.W(G)) u_d02 (.a(s02a), .b(s02b), .p(d02));
    hk_school #(.W(G)) u_d12 (.a(s12a), .b(s12b), .p(d12));

    // middle coefficients of the three-term product
    assign t1 = d01 ^ d0 ^ d1;
    assign t2 = d02 ^ d0 ^ d2 ^ d1;
    assign t3 = d12 ^ d1 ^ d2;

    // merge overlapping terms at group offsets; bits above PW are zero
    always_comb begin
        p = PW'(FW'(d0))
          ^ PW'(FW'(t1) << G)
          ^ PW'(FW'(t2) << (2 * G))
          ^ PW'(FW'(t3) << (3 * G))
          ^ PW'(FW'(d2) << (4 * G));
    end
endmodule

// File: rtl/hk_node.sv
`timescale 1ns/1ps
module hk_node
    import hk_pkg::*;
#(
    parameter int W      = 233,
    parameter int THRESH = 32
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-2:0]   p
);
    localparam int  PW      = prod_width(W);
    localparam bit  AT_LEAF = is_leaf(W, THRESH);

    generate
        if (AT_LEAF) begin : g_leaf
            hk_leaf3 #(.W(W)) u_leaf (.a(a), .b(b), .p(p));
        end else begin : g_split
            localparam int L   = low_half(W);
            localparam int H   = W - L;
            localparam int LPW = prod_width(L);
            localparam int HPW = prod_width(H);

            logic [L-1:0]   a_lo, b_lo;
            logic [H-1:0]   a_hi, b_hi, a_sum, b_sum;
            logic [LPW-1:0] p_lo;
            logic [HPW-1:0] p_hi, p_mid, mid;

            assign a_lo  = a[L-1:0];
            assign b_lo  = b[L-1:0];
            assign a_hi  = a[W-1:L];
            assign b_hi  = b[W-1:L];
            assign a_sum = a_hi ^ H'(a_lo);
            assign b_sum = b_hi ^ H'(b_lo);

            hk_node #(.W(L), .THRESH(THRESH)) u_lo  (.a(a_lo),  .b(b_lo),  .p(p_lo));
            hk_node #(.W(H), .THRESH(THRESH)) u_hi  (.a(a_hi),  .b(b_hi),  .p(p_hi));
            hk_node #(.W(H), .THRESH(THRESH)) u_mid (.a(a_sum), .b(b_sum), .p(p_mid));

            // cross term: (lo+hi)^2-product minus the two outer products
            assign mid = p_mid ^ p_hi ^ HPW'(p_lo);

            always_comb begin
                p = PW'(p_lo)
                  ^ (PW'(mid)  << L)
                  ^ (PW'(p_hi) << (2 * L));
            end
        end
    endgenerate
endmodule

// File: rtl/hk_polymul.sv
`timescale 1ns/1ps
module hk_polymul
    import hk_pkg::*;
#(
    parameter int N       = 233,
    parameter int THRESH  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      a,
    input  logic [N-1:0]      b,
    output logic [2*N-2:0]    prod
);
    localparam int PW = prod_width(N);

    logic [PW-1:0] comb_prod;

    hk_node #(.W(N), .THRESH(THRESH)) u_tree (
        .a (a),
        .b (b),
        .p (comb_prod)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod <= '0;
                end else begin
                    prod <= comb_prod;
                end
            end

            // R6
            reg_identity_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (b == N'(1)) |=> (prod == PW'($past(a))));
        end else begin : g_comb
            assign prod = comb_prod;
        end
    endgenerate

    // R2
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a == '0) || (b == '0)) |-> (comb_prod == '0));

    // R3
    identity_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b == N'(1)) |-> (comb_prod == PW'(a)));

    // R4
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(a) && $onehot(b)) |-> ($countones(comb_prod) == 1));

    // R5
    top_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (comb_prod[PW-1] == (a[N-1] & b[N-1])));

    // R5
    low_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (comb_prod[0] == (a[0] & b[0])));
endmodule

// File: tb/hk_polymul_bench.sv
`timescale 1ns/1ps
module hk_polymul_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [12:0]  a13, b13;
    logic [24:0]  p13;
    logic [7:0]   a8, b8;
    logic [14:0]  p8;
    logic [232:0] a233, b233;
    logic [464:0] p233;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hk_polymul #(.N(13), .THRESH(5), .OUT_REG(1'b1)) u_hk_polymul (
        .clk(clk), .rst_n(rst_n), .a(a13), .b(b13), .prod(p13));

    hk_polymul #(.N(8), .THRESH(3), .OUT_REG(1'b0)) u_hk_polymul_n8 (
        .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .prod(p8));

    hk_polymul u_hk_polymul_n233 (
        .clk(clk), .rst_n(rst_n), .a(a233), .b(b233), .prod(p233));

    // schoolbook shift-and-XOR model
    function automatic logic [464:0] ref_mul(input logic [232:0] x, input logic [232:0] y, input int n);
        logic [464:0] r = '0;
        for (int i = 0; i < n; i++) begin
            if (y[i]) r = r ^ (465'(x) << i);
        end
        return r;
    endfunction

    function automatic logic [232:0] rnd233();
        return 233'({$urandom, $urandom, $urandom, $urandom,
                     $urandom, $urandom, $urandom, $urandom});
    endfunction

    task automatic chk(input string tag, input logic [464:0] act, input logic [464:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, let the register capture, sample 1 ns after
    task automatic apply(input logic [12:0] x13, input logic [12:0] y13,
                         input logic [7:0] x8, input logic [7:0] y8,
                         input logic [232:0] x233, input logic [232:0] y233);
        @(negedge clk);
        a13 = x13; b13 = y13; a8 = x8; b8 = y8; a233 = x233; b233 = y233;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " n13"},  465'(p13), ref_mul(233'(a13), 233'(b13), 13));
        chk({tag, " n8"},   465'(p8),  ref_mul(233'(a8),  233'(b8),  8));
        chk({tag, " n233"}, p233,      ref_mul(a233, b233, 233));
    endtask

    initial begin
        logic [24:0]  keep13;
        logic [464:0] keep233;
        logic [232:0] x, y;
        a13 = 13'h5; b13 = 13'h3; a8 = 8'h0; b8 = 8'h0; a233 = '0; b233 = '0;

        // R7: register held at zero while reset is low
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset n13", 465'(p13), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: zero operand
        apply(13'h0, 13'h1a5b, 8'h00, 8'hc3, '0, rnd233());
        check_all("R2 a=0");
        chk("R2 zero n13", 465'(p13), '0);
        apply(13'h0f0f, 13'h0, 8'h5a, 8'h00, rnd233(), '0);
        check_all("R2 b=0");
        chk("R2 zero n233", p233, '0);

        // R3: identity operand
        x = rnd233();
        apply(13'h1, 13'h1357, 8'h01, 8'hb7, 233'h1, x);
        check_all("R3 a=1");
        chk("R3 ident n233", p233, 465'(x));
        apply(13'h1fed, 13'h1, 8'he4, 8'h01, x, 233'h1);
        chk("R3 ident n13", 465'(p13), 465'(13'h1fed));

        // R5: all-ones operands and extreme coefficients
        apply('1, '1, '1, '1, '1, '1);
        check_all("R5 all-ones");
        chk("R5 top bit n233", 465'(p233[464]), 465'(1'b1));
        chk("R5 top bit n13", 465'(p13[24]), 465'(1'b1));

        // R4: every single-bit pair for N=13, edge positions for N=233
        for (int i = 0; i < 13; i++) begin
            for (int j = 0; j < 13; j++) begin
                apply(13'(1) << i, 13'(1) << j, 8'(1) << (i % 8), 8'(1) << (j % 8),
                      233'(1) << (i * 18), 233'(1) << (232 - j * 18));
                chk("R4 single n13", 465'(p13), 465'(1) << (i + j));
                chk("R4 single n8", 465'(p8), 465'(1) << ((i % 8) + (j % 8)));
                chk("R4 single n233", p233, 465'(1) << (i * 18 + 232 - j * 18));
            end
        end

        // R8: swapped operands give the same product
        for (int k = 0; k < 20; k++) begin
            x = rnd233();
            y = rnd233();
            apply(x[12:0], y[12:0], x[20:13], y[20:13], x, y);
            keep13 = p13;
            keep233 = p233;
            apply(y[12:0], x[12:0], y[20:13], x[20:13], y, x);
            chk("R8 swap n13", 465'(p13), 465'(keep13));
            chk("R8 swap n233", p233, keep233);
        end

        // R6: registered output holds between edges, then follows
        apply(13'h0abc, 13'h1234, 8'h11, 8'h22, rnd233(), rnd233());
        keep13 = p13;
        @(negedge clk);
        a13 = 13'h1111; b13 = 13'h0777;
        #1;
        chk("R6 hold n13", 465'(p13), 465'(keep13));
        chk("R6 hold ref n13", 465'(keep13), ref_mul(233'(13'h0abc), 233'(13'h1234), 13));
        @(posedge clk);
        #1;
        chk("R6 follow n13", 465'(p13), ref_mul(233'(13'h1111), 233'(13'h0777), 13));

        // R1: exhaustive N=8 sweep, random N=13 and N=233 alongside
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                if ((ib % 64) == 0) begin
                    apply(13'($urandom), 13'($urandom), 8'(ia), 8'(ib), rnd233(), rnd233());
                    check_all("R1 sweep");
                end else begin
                    apply(13'($urandom), 13'($urandom), 8'(ia), 8'(ib), a233, b233);
                    chk("R1 sweep n13", 465'(p13), ref_mul(233'(a13), 233'(b13), 13));
                    chk("R1 sweep n8", 465'(p8), ref_mul(233'(a8), 233'(b8), 8));
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule